// File: doc/BRIEF.md
# Coalescing Store Buffer with Load Forwarding

This block holds executed stores between a core's execute stage and the write port of a data cache. Each store carries a word address, four byte enables and a 32-bit data word. It is accepted through a valid/ready handshake and queued. The oldest queued word is offered to the cache. It leaves the queue when the cache accepts it, so words reach the cache in the order their stores were accepted.

Narrow stores that hit the same word as the youngest queued entry are folded into that entry, which saves cache write cycles. The block does not fold into the entry currently offered to the cache. A combinational lookup port lets a load see queued bytes without waiting for them to drain. For each byte it returns the value from the youngest entry that wrote it, plus a mask of the bytes it covered.

A fence pulse stops further stores and waits until the queue is empty. It then raises a one-cycle acknowledge. All addresses on the ports are word addresses, meaning the byte address shifted right by two.

Top module: `sbuf_top`

## Requirements
- R1: Words are written to the cache in the order their stores were accepted. No younger entry is presented before an older one has been taken by the cache.
- R2: `ld_hit_o[b]` is 1 when any queued entry for word `ld_addr_i` has byte b enabled. In that case, byte b of `ld_data_o` (bits 8b+7:8b) comes from the youngest such entry. Bytes that are not covered read as 0 with hit 0.
- R3: A store to the same word address as the youngest entry is folded into that entry when at least two entries are queued. Its enabled bytes overwrite the old bytes, its enable bits are OR-ed in, and no new entry is taken.
- R4: When only one entry is queued, that entry is the one offered to the cache. A store to its word therefore opens a new entry instead of folding.
- R5: While `cw_valid_o` is high and `cw_ready_i` is low, the offered word address, byte enables and data hold steady. A word is handed over on a cycle where both are high.
- R6: When all DEPTH entries are occupied, `st_ready_o` is low.
- R7: `fence_ack_o` rises only when the queue is empty, and no earlier than the cycle after the request. It stays high for exactly one cycle.
- R8: From the cycle of `fence_req_i` until the acknowledge cycle, `st_ready_o` is low.
- R9: After reset the queue is empty: `cw_valid_o`=0, `st_ready_o`=1, `fence_ack_o`=0 and `ld_hit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_ready_o | output | 1 | Store can be taken this cycle |
| st_addr_i | input | 30 | Store word address |
| st_be_i | input | 4 | Store byte enables |
| st_data_i | input | 32 | Store data |
| ld_addr_i | input | 30 | Lookup word address |
| ld_data_o | output | 32 | Forwarded bytes |
| ld_hit_o | output | 4 | Per-byte forward hit |
| fence_req_i | input | 1 | Fence request pulse |
| fence_ack_o | output | 1 | Fence done pulse |
| cw_valid_o | output | 1 | Cache write offered |
| cw_ready_i | input | 1 | Cache accepts write |
| cw_addr_o | output | 30 | Cache write word address |
| cw_be_o | output | 4 | Cache write byte enables |
| cw_data_o | output | 32 | Cache write data |

## Verification
The checks assume that every store carries at least one enabled byte. They also assume that `fence_req_i` is a single-cycle pulse and is not raised again before its acknowledge. The directed tasks keep to both rules: every store has a nonzero enable, and every fence is one pulse followed by a wait for the acknowledge. The stimulus holds `cw_ready_i` low to build up queued entries. This sets up the full, fold and fence-wait conditions, and it only releases the cache when each scenario needs draining.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = 8 * WORD_BYTES;
  localparam int OFS_W      = $clog2(WORD_BYTES);
  localparam int WADDR_W    = ADDR_W - OFS_W;

  typedef struct packed {
    logic [WADDR_W-1:0]    waddr;
    logic [WORD_BYTES-1:0] be;
    logic [DATA_W-1:0]     data;
  } sb_entry_t;
endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic [WADDR_W-1:0]    push_waddr_i,
  input  logic [WORD_BYTES-1:0] push_be_i,
  input  logic [DATA_W-1:0]     push_data_i,
  input  logic                  pop_i,
  output sb_entry_t             ent_o [DEPTH],
  output logic [IDX_W-1:0]      head_o,
  output logic [CNT_W-1:0]      count_o
);
  sb_entry_t        ent_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q, young;
  logic [CNT_W-1:0] count_q;
  logic             merge, alloc;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign young = (tail_q == '0) ? IDX_W'(DEPTH - 1) : tail_q - 1'b1;
  // fold only when the youngest entry is not the one at the cache port
  assign merge = push_i && (count_q >= CNT_W'(2)) && (ent_q[young].waddr == push_waddr_i);
  assign alloc = push_i && !merge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      if (merge) begin
        ent_q[young].be <= ent_q[young].be | push_be_i;
        for (int b = 0; b < WORD_BYTES; b++)
          if (push_be_i[b]) ent_q[young].data[8*b +: 8] <= push_data_i[8*b +: 8];
      end else if (alloc) begin
        ent_q[tail_q] <= '{waddr: push_waddr_i, be: push_be_i, data: push_data_i};
        tail_q        <= wrap_inc(tail_q);
      end
      if (pop_i) head_q <= wrap_inc(head_q);
      count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop_i);
    end
  end

  assign ent_o   = ent_q;
  assign head_o  = head_q;
  assign count_o = count_q;
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  sb_entry_t             ent_i [DEPTH],
  input  logic [IDX_W-1:0]      head_i,
  input  logic [CNT_W-1:0]      count_i,
  input  logic [WADDR_W-1:0]    ld_waddr_i,
  output logic [DATA_W-1:0]     data_o,
  output logic [WORD_BYTES-1:0] hit_o
);
  // walk oldest to youngest so younger matches overwrite
  always_comb begin
    logic [IDX_W:0] s;
    logic [IDX_W-1:0] idx;
    data_o = '0;
    hit_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s = {1'b0, head_i} + (IDX_W+1)'(i);
      if (s >= (IDX_W+1)'(DEPTH)) s = s - (IDX_W+1)'(DEPTH);
      idx = s[IDX_W-1:0];
      if ((CNT_W'(i) < count_i) && (ent_i[idx].waddr == ld_waddr_i)) begin
        for (int b = 0; b < WORD_BYTES; b++) begin
          if (ent_i[idx].be[b]) begin
            data_o[8*b +: 8] = ent_i[idx].data[8*b +: 8];
            hit_o[b]         = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbuf_fence.sv
module sbuf_fence (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic empty_i,
  output logic ack_o,
  output logic block_o
);
  logic pend_q;

  assign ack_o   = pend_q && empty_i;
  assign block_o = pend_q || req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (req_i) pend_q <= 1'b1;
    else if (ack_o) pend_q <= 1'b0;
  end
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  st_valid_i,
  output logic                  st_ready_o,
  input  logic [WADDR_W-1:0]    st_addr_i,
  input  logic [WORD_BYTES-1:0] st_be_i,
  input  logic [DATA_W-1:0]     st_data_i,
  input  logic [WADDR_W-1:0]    ld_addr_i,
  output logic [DATA_W-1:0]     ld_data_o,
  output logic [WORD_BYTES-1:0] ld_hit_o,
  input  logic                  fence_req_i,
  output logic                  fence_ack_o,
  output logic                  cw_valid_o,
  input  logic                  cw_ready_i,
  output logic [WADDR_W-1:0]    cw_addr_o,
  output logic [WORD_BYTES-1:0] cw_be_o,
  output logic [DATA_W-1:0]     cw_data_o
);
  sb_entry_t        ent [DEPTH];
  logic [IDX_W-1:0] head;
  logic [CNT_W-1:0] count_q;
  logic             full, block, push, pop;

  assign full       = (count_q == CNT_W'(DEPTH));
  assign st_ready_o = !full && !block;
  assign push       = st_valid_i && st_ready_o;
  assign cw_valid_o = (count_q != '0);
  assign pop        = cw_valid_o && cw_ready_i;
  assign cw_addr_o  = ent[head].waddr;
  assign cw_be_o    = ent[head].be;
  assign cw_data_o  = ent[head].data;

  sbuf_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_waddr_i (st_addr_i),
    .push_be_i    (st_be_i),
    .push_data_i  (st_data_i),
    .pop_i        (pop),
    .ent_o        (ent),
    .head_o       (head),
    .count_o      (count_q)
  );

  sbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
    .ent_i      (ent),
    .head_i     (head),
    .count_i    (count_q),
    .ld_waddr_i (ld_addr_i),
    .data_o     (ld_data_o),
    .hit_o      (ld_hit_o)
  );

  sbuf_fence u_fence (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (fence_req_i),
    .empty_i (!cw_valid_o),
    .ack_o   (fence_ack_o),
    .block_o (block)
  );
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  st_ready_o,
  input logic                  fence_req_i,
  input logic                  fence_ack_o,
  input logic                  cw_valid_o,
  input logic                  cw_ready_i,
  input logic [WADDR_W-1:0]    cw_addr_o,
  input logic [WORD_BYTES-1:0] cw_be_o,
  input logic [DATA_W-1:0]     cw_data_o,
  input logic [CNT_W-1:0]      count_q
);
  assert_hold_head_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_valid_o && !cw_ready_i |=> cw_valid_o && $stable(cw_addr_o) && $stable(cw_be_o) && $stable(cw_data_o));

  assert_head_has_bytes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_valid_o |-> cw_be_o != '0);

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, count_q} <= {1'b0, $past(count_q)} + 1'b1));

  assert_full_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q == CNT_W'(DEPTH) |-> !st_ready_o);

  assert_fence_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_ack_o |-> !cw_valid_o);

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_ack_o |=> !fence_ack_o);

  assert_fence_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_req_i |-> !st_ready_o);

  assert_block_until_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_req_i |=> !st_ready_o);
endmodule

bind sbuf_top sbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_ready_o  (st_ready_o),
  .fence_req_i (fence_req_i),
  .fence_ack_o (fence_ack_o),
  .cw_valid_o  (cw_valid_o),
  .cw_ready_i  (cw_ready_i),
  .cw_addr_o   (cw_addr_o),
  .cw_be_o     (cw_be_o),
  .cw_data_o   (cw_data_o),
  .count_q     (count_q)
);

// File: tb/tb_sbuf_top.sv
module tb_sbuf_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0;
  logic        st_ready_o;
  logic [29:0] st_addr_i = '0;
  logic [3:0]  st_be_i = '0;
  logic [31:0] st_data_i = '0;
  logic [29:0] ld_addr_i = '0;
  logic [31:0] ld_data_o;
  logic [3:0]  ld_hit_o;
  logic        fence_req_i = 1'b0;
  logic        fence_ack_o;
  logic        cw_valid_o;
  logic        cw_ready_i = 1'b0;
  logic [29:0] cw_addr_o;
  logic [3:0]  cw_be_o;
  logic [31:0] cw_data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] ref_mem   [64];
  logic [31:0] cache_mem [64];
  logic [29:0] log_addr  [256];
  logic [3:0]  log_be    [256];
  int          n_commit = 0;

  always #10 clk = ~clk;

  sbuf_top #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o),
    .st_addr_i(st_addr_i), .st_be_i(st_be_i), .st_data_i(st_data_i),
    .ld_addr_i(ld_addr_i), .ld_data_o(ld_data_o), .ld_hit_o(ld_hit_o),
    .fence_req_i(fence_req_i), .fence_ack_o(fence_ack_o),
    .cw_valid_o(cw_valid_o), .cw_ready_i(cw_ready_i),
    .cw_addr_o(cw_addr_o), .cw_be_o(cw_be_o), .cw_data_o(cw_data_o)
  );

  // cache model: takes each handed-over word at the edge
  always @(posedge clk) begin
    if (rst_ni && cw_valid_o && cw_ready_i) begin
      for (int b = 0; b < 4; b++)
        if (cw_be_o[b]) cache_mem[cw_addr_o[5:0]][8*b +: 8] <= cw_data_o[8*b +: 8];
      log_addr[n_commit[7:0]] = cw_addr_o;
      log_be[n_commit[7:0]]   = cw_be_o;
      n_commit = n_commit + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [29:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    st_valid_i = 1'b1; st_addr_i = a; st_be_i = be; st_data_i = d;
    #1;
    while (!st_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    for (int b = 0; b < 4; b++)
      if (be[b]) ref_mem[a[5:0]][8*b +: 8] = d[8*b +: 8];
    #1 st_valid_i = 1'b0;
  endtask

  task automatic load(input logic [29:0] a, input logic [3:0] exp_hit,
                      input logic [31:0] exp_data, input string req);
    @(negedge clk);
    ld_addr_i = a;
    #1;
    chk(ld_hit_o == exp_hit, req, "load hit", 64'(ld_hit_o), 64'(exp_hit));
    chk(ld_data_o == exp_data, req, "load data", 64'(ld_data_o), 64'(exp_data));
  endtask

  // one-pulse fence, wait for ack, check empty at ack and one-cycle pulse
  task automatic do_fence(input int min_wait);
    int cyc = 0;
    bit seen = 0;
    @(negedge clk);
    fence_req_i = 1'b1;
    #1;
    chk(st_ready_o == 1'b0, "R8", "ready on fence cycle", 64'(st_ready_o), 0);
    @(negedge clk);
    fence_req_i = 1'b0;
    while (!seen && cyc < 200) begin
      #1;
      if (fence_ack_o) seen = 1;
      else begin
        if (cyc == 0) chk(st_ready_o == 1'b0, "R8", "ready while fence pending", 64'(st_ready_o), 0);
        @(negedge clk);
        cyc++;
      end
    end
    chk(seen, "R7", "fence ack seen", 64'(seen), 1);
    chk(cyc >= min_wait, "R7", "ack wait cycles", 64'(cyc), 64'(min_wait));
    chk(cw_valid_o == 1'b0, "R7", "queue empty at ack", 64'(cw_valid_o), 0);
    @(negedge clk);
    #1;
    chk(fence_ack_o == 1'b0, "R7", "ack one cycle", 64'(fence_ack_o), 0);
    chk(st_ready_o == 1'b1, "R8", "ready after ack", 64'(st_ready_o), 1);
  endtask

  task automatic t_reset;
    #1;
    chk(cw_valid_o == 1'b0, "R9", "cw_valid after reset", 64'(cw_valid_o), 0);
    chk(st_ready_o == 1'b1, "R9", "st_ready after reset", 64'(st_ready_o), 1);
    chk(fence_ack_o == 1'b0, "R9", "ack after reset", 64'(fence_ack_o), 0);
    chk(ld_hit_o == 4'h0, "R9", "hit after reset", 64'(ld_hit_o), 0);
  endtask

  task automatic t_order;
    int n0;
    @(negedge clk) cw_ready_i = 1'b0;
    push(30'h1, 4'hF, 32'h0101_0101);
    push(30'h2, 4'hF, 32'h0202_0202);
    push(30'h3, 4'hF, 32'h0303_0303);
    @(negedge clk); #1;
    chk(cw_valid_o && cw_addr_o == 30'h1, "R5", "head held while stalled", 64'(cw_addr_o), 1);
    chk(cw_data_o == 32'h0101_0101, "R5", "head data held", 64'(cw_data_o), 64'h0101_0101);
    n0 = n_commit;
    cw_ready_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_commit - n0 == 3, "R1", "commit count", 64'(n_commit - n0), 3);
    for (int k = 0; k < 3; k++)
      chk(log_addr[(n0 + k) % 256] == 30'(k + 1), "R1", "commit order",
          64'(log_addr[(n0 + k) % 256]), 64'(k + 1));
  endtask

  task automatic t_merge;
    int n0;
    @(negedge clk) cw_ready_i = 1'b0;
    n0 = n_commit;
    push(30'h5, 4'b0001, 32'h0000_00A1);
    push(30'h5, 4'b0010, 32'h0000_B200);
    push(30'h5, 4'b0100, 32'h00C3_0000);
    push(30'h5, 4'b1000, 32'hD400_0000);
    load(30'h5, 4'hF, 32'hD4C3_B2A1, "R2");
    @(negedge clk) cw_ready_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_commit - n0 == 2, "R3", "folded commit count", 64'(n_commit - n0), 2);
    chk(log_be[n0 % 256] == 4'b0001, "R4", "head entry not folded", 64'(log_be[n0 % 256]), 1);
    chk(log_be[(n0 + 1) % 256] == 4'b1110, "R3", "folded enables", 64'(log_be[(n0 + 1) % 256]), 64'hE);
    chk(cache_mem[5] == 32'hD4C3_B2A1, "R3", "folded word in cache", 64'(cache_mem[5]), 64'hD4C3_B2A1);
  endtask

  task automatic t_forward;
    @(negedge clk) cw_ready_i = 1'b0;
    push(30'h10, 4'hF, 32'h4433_2211);
    push(30'h11, 4'hF, 32'h5555_5555);
    push(30'h10, 4'b0010, 32'h0000_AB00);
    load(30'h10, 4'hF, 32'h4433_AB11, "R2");
    load(30'h10, 4'hF, ref_mem[6'h10], "R2");
    load(30'h12, 4'h0, 32'h0, "R2");
    push(30'h13, 4'b0100, 32'h00CC_0000);
    load(30'h13, 4'b0100, 32'h00CC_0000, "R2");
    @(negedge clk) cw_ready_i = 1'b1;
    do_fence(0);
    load(30'h10, 4'h0, 32'h0, "R2");
  endtask

  task automatic t_full;
    @(negedge clk) cw_ready_i = 1'b0;
    for (int k = 0; k < DEPTH; k++) push(30'(32 + k), 4'hF, 32'(k * 32'h0100_0001));
    @(negedge clk);
    st_valid_i = 1'b1; st_addr_i = 30'h30; st_be_i = 4'hF; st_data_i = 32'hFEED_0001;
    #1;
    chk(st_ready_o == 1'b0, "R6", "ready when full", 64'(st_ready_o), 0);
    @(negedge clk); #1;
    chk(st_ready_o == 1'b0, "R6", "still stalled", 64'(st_ready_o), 0);
    st_valid_i = 1'b0;
    cw_ready_i = 1'b1;
    push(30'h30, 4'hF, 32'hFEED_0001);
  endtask

  task automatic t_fence;
    int n0;
    do_fence(0);
    @(negedge clk) cw_ready_i = 1'b0;
    push(30'h31, 4'hF, 32'h3131_3131);
    push(30'h32, 4'hF, 32'h3232_3232);
    n0 = n_commit;
    fork
      do_fence(3);
      begin
        repeat (5) @(negedge clk);
        cw_ready_i = 1'b1;
      end
    join
    chk(n_commit - n0 == 2, "R7", "all entries done before ack", 64'(n_commit - n0), 2);
  endtask

  task automatic t_final;
    int mism = 0;
    do_fence(0);
    repeat (2) @(negedge clk);
    for (int w = 0; w < 64; w++) if (cache_mem[w] !== ref_mem[w]) mism++;
    chk(mism == 0, "R1", "final cache vs model", 64'(mism), 0);
  endtask

  initial begin
    for (int w = 0; w < 64; w++) begin
      ref_mem[w] = '0;
      cache_mem[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_order;
    t_merge;
    t_forward;
    t_full;
    t_fence;
    t_final;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule